// File: doc/BRIEF.md
# Commanded Power Switch Controller

This block drives a bank of on/off power switches purely from commands. Each supply rail has one master switch, and each supply feeds a fixed group of branch switches that carry it to individual loads. A branch delivers power only while its own enable and its parent supply's enable are both set. An external comparator per switch reports over-current; a sustained over-current trips the switch off and latches a trip flag that stays until a reset command clears it.

Commands can turn a switch on, turn it off, reset a tripped switch back on, or force a switch on so that it ignores its over-current input. The low-voltage rail (supply switch 0) must be on before the higher-voltage rail (supply switch 1) may be turned on. A sequenced command turns on the low rail and then the high rail after a programmable gap. The enable, trip and force bits of every switch are always visible on a status vector for housekeeping.

Top module: `pwr_switch_ctrl`

## Requirements
- R1: During and after reset, with no command given, every enable, trip and force bit is 0 and every switch output is 0.
- R2: Opcode 0x11 (on) sets the addressed switch's enable unless its trip bit is 1; opcode 0x22 (off) clears its enable and force bits and leaves the trip bit. No enable bit rises without a command.
- R3: Switch indices 0..N_SUP-1 are supply masters; index N_SUP + s*N_BR + b is branch b of supply s. A master's output equals its enable; a branch's output is its enable AND its parent supply's enable.
- R4: Over-current sampled high on an active output for 4 consecutive clock edges sets the trip bit on the 4th edge and clears the enable unless the switch is forced; shorter runs have no effect.
- R5: Opcode 0x33 (reset) clears the trip bit and sets the enable of the addressed switch.
- R6: Opcode 0x44 (force) sets the enable and force bits even when tripped; while forced, a declared over-current still sets the trip bit but leaves the enable set, until an off command clears both.
- R7: On, reset and force commands addressed to switch 1 are ignored while switch 0's enable is 0.
- R8: Opcode 0x55 (sequence, index ignored) sets switch 0's enable on the same edge, then requests switch 1 on D+1 edges later (D = cfg_seq_dly at the command); the request is dropped if an off command to switch 0 or 1 arrives meanwhile, or if switch 0 is off at that moment.
- R9: Commands with any other opcode, or with an index of N_SUP*(1+N_BR) or more, change nothing.
- R10: status holds 3 bits per switch i: bit 3i enable, bit 3i+1 trip, bit 3i+2 force.
- R11: Within one edge, off beats force, force beats reset, reset beats on; an over-current declared on that edge then sets trip and clears the enable unless the resulting force bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_idx | input | IDX_W | Switch index addressed |
| cfg_seq_dly | input | DLY_W | Gap D for the sequenced turn-on |
| oc_in | input | NSW | Per-switch over-current indications |
| sw_out | output | NSW | Per-switch drive (power delivered) |
| status | output | 3*NSW | Enable, trip and force bits per switch |

## Verification
The assertions take for granted that oc_in and the command inputs are synchronous to clk and stable around its edge, and that the filter length is at least two cycles. They also assume nothing but the command port and the trip filter moves an enable. The bench drives every input half a cycle away from the active edge. It holds over-current levels for runs of random length so that both rejected glitches and full trips occur, including on forced switches and in the same cycle as commands.

// File: rtl/pwr_sw_pkg.sv
// Package: opcodes and per-switch status record for the power switch controller.
package pwr_sw_pkg;
    typedef enum logic [7:0] {
        OP_ON    = 8'h11,
        OP_OFF   = 8'h22,
        OP_RESET = 8'h33,
        OP_FORCE = 8'h44,
        OP_SEQ   = 8'h55
    } pwr_op_e;

    // Packed so that bit 0 is enable, bit 1 trip, bit 2 force.
    typedef struct packed {
        logic force_on;
        logic tripped;
        logic enabled;
    } sw_stat_t;
endpackage

// File: rtl/pwr_oc_filter.sv
// Module: pwr_oc_filter
// Declares an over-current trip once oc_in has been seen high on an active
// output for OC_CYC consecutive edges. Assumes OC_CYC >= 2 and oc_in is
// synchronous to clk.
module pwr_oc_filter #(
    parameter int OC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic oc_in,
    output logic trip_hit
);
    localparam int CNT_W = (OC_CYC > 2) ? $clog2(OC_CYC) : 1;

    logic [CNT_W-1:0] run_q;

    assign trip_hit = active && oc_in && (run_q == CNT_W'(OC_CYC - 1));

    // Count consecutive qualified over-current samples; restart on any gap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (trip_hit)
            run_q <= '0;
        else if (active && oc_in)
            run_q <= run_q + CNT_W'(1);
        else
            run_q <= '0;
    end

    // R4
    trip_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_hit |-> $past(active && oc_in));
endmodule

// File: rtl/pwr_rail_seq.sv
// Module: pwr_rail_seq
// Timer for the sequenced turn-on: after start, fires once dly+1 edges
// later unless cancelled. A new start restarts the wait.
module pwr_rail_seq #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    input  logic [DLY_W-1:0] dly,
    output logic             fire
);
    logic             pend_q;
    logic [DLY_W-1:0] cnt_q;

    assign fire = pend_q && (cnt_q == '0) && !cancel;

    // Hold the pending flag and count the remaining gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            pend_q <= 1'b1;
            cnt_q  <= dly;
        end else if (cancel || fire) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    // R8
    seq_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !start) |=> !pend_q);
endmodule

// File: rtl/pwr_switch_cell.sv
// Module: pwr_switch_cell
// State of one switch: enable, latched trip and force. Applies the command
// priority off > force > reset > on, then a declared trip. Assumes at most
// the gated requests of one command arrive per cycle.
module pwr_switch_cell
    import pwr_sw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_on,
    input  logic     req_off,
    input  logic     req_reset,
    input  logic     req_force,
    input  logic     trip_hit,
    output sw_stat_t stat_o
);
    sw_stat_t stat_q, stat_d;

    // Next state from the command, then the trip override.
    always_comb begin
        stat_d = stat_q;
        if (req_off) begin
            stat_d.enabled  = 1'b0;
            stat_d.force_on = 1'b0;
        end else if (req_force) begin
            stat_d.enabled  = 1'b1;
            stat_d.force_on = 1'b1;
        end else if (req_reset) begin
            stat_d.enabled = 1'b1;
            stat_d.tripped = 1'b0;
        end else if (req_on && !stat_q.tripped) begin
            stat_d.enabled = 1'b1;
        end
        if (trip_hit) begin
            stat_d.tripped = 1'b1;
            if (!stat_d.force_on)
                stat_d.enabled = 1'b0;
        end
    end

    // Register the switch state.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R2
    no_auto_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q.enabled) |-> $past(req_on || req_reset || req_force));
    // R4
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_hit && !stat_q.force_on && !req_force) |=> (!stat_q.enabled && stat_q.tripped));
    // R6
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q.force_on && !req_off) |=> stat_q.enabled);
endmodule

// File: rtl/pwr_switch_ctrl.sv
// Module: pwr_switch_ctrl (top)
// Bank of N_SUP supply masters, each feeding N_BR branch switches, driven
// by commands. Decodes commands, gates the high rail on the low rail,
// runs the sequenced turn-on and per-switch over-current filters.
// Assumes inputs are synchronous to clk.
module pwr_switch_ctrl
    import pwr_sw_pkg::*;
#(
    parameter int N_SUP   = 3,
    parameter int N_BR    = 2,
    parameter int OC_CYC  = 4,
    parameter int DLY_W   = 8,
    parameter int IDX_W   = 8,
    parameter int LO_RAIL = 0,
    parameter int HI_RAIL = 1,
    parameter int NSW     = N_SUP * (1 + N_BR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [DLY_W-1:0] cfg_seq_dly,
    input  logic [NSW-1:0]   oc_in,
    output logic [NSW-1:0]   sw_out,
    output logic [3*NSW-1:0] status
);
    localparam int ST_W = 3;

    sw_stat_t       st [NSW];
    logic [NSW-1:0] en_v;
    logic [NSW-1:0] active;
    logic [NSW-1:0] hit;
    logic           cmd_ok, op_on, op_off, op_reset, op_force;
    logic           seq_start, seq_cancel, seq_fire, lo_on;

    assign cmd_ok     = cmd_valid && (int'(cmd_idx) < NSW);
    assign op_on      = cmd_ok && (cmd_op == OP_ON);
    assign op_off     = cmd_ok && (cmd_op == OP_OFF);
    assign op_reset   = cmd_ok && (cmd_op == OP_RESET);
    assign op_force   = cmd_ok && (cmd_op == OP_FORCE);
    assign seq_start  = cmd_valid && (cmd_op == OP_SEQ);
    assign seq_cancel = op_off && ((int'(cmd_idx) == LO_RAIL) || (int'(cmd_idx) == HI_RAIL));
    assign lo_on      = en_v[LO_RAIL];

    pwr_rail_seq #(.DLY_W(DLY_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (seq_start),
        .cancel (seq_cancel),
        .dly    (cfg_seq_dly),
        .fire   (seq_fire)
    );

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        localparam int PAR   = (i < N_SUP) ? i : (i - N_SUP) / N_BR;
        localparam bit IS_LO = (i == LO_RAIL);
        localparam bit IS_HI = (i == HI_RAIL);

        logic sel, gate, r_on, r_off, r_reset, r_force;

        assign sel     = (int'(cmd_idx) == i);
        assign gate    = IS_HI ? lo_on : 1'b1;
        assign r_on    = gate && ((op_on && sel) || (IS_LO && seq_start) || (IS_HI && seq_fire));
        assign r_off   = op_off && sel;
        assign r_reset = gate && op_reset && sel;
        assign r_force = gate && op_force && sel;

        pwr_switch_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_on    (r_on),
            .req_off   (r_off),
            .req_reset (r_reset),
            .req_force (r_force),
            .trip_hit  (hit[i]),
            .stat_o    (st[i])
        );

        assign en_v[i] = st[i].enabled;
        assign status[ST_W*i +: ST_W] = st[i];

        if (i < N_SUP) begin : g_master
            assign active[i] = en_v[i];
        end else begin : g_branch
            assign active[i] = en_v[i] && en_v[PAR];
            // R3
            branch_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sw_out[i] |-> st[PAR].enabled);
        end

        pwr_oc_filter #(.OC_CYC(OC_CYC)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active[i]),
            .oc_in    (oc_in[i]),
            .trip_hit (hit[i])
        );
    end

    assign sw_out = active;

    // R7
    hi_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_v[HI_RAIL]) |-> $past(en_v[LO_RAIL]));
endmodule

// File: tb/pwr_switch_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_switch_ctrl_tb;
    localparam int N_SUP = 3;
    localparam int N_BR  = 2;
    localparam int NSW   = N_SUP * (1 + N_BR);
    localparam int OCN   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_op = 8'h00;
    logic [7:0]       cmd_idx = 8'h00;
    logic [7:0]       cfg_seq_dly = 8'd0;
    logic [NSW-1:0]   oc_in = '0;
    logic [NSW-1:0]   sw_out;
    logic [3*NSW-1:0] status;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    bit m_en [NSW];
    bit m_tr [NSW];
    bit m_fo [NSW];
    int m_cnt[NSW];
    bit m_pend;
    int m_scnt;

    always #2 clk = ~clk;

    pwr_switch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cfg_seq_dly(cfg_seq_dly), .oc_in(oc_in),
        .sw_out(sw_out), .status(status)
    );

    function automatic int parent(int i);
        return (i < N_SUP) ? i : (i - N_SUP) / N_BR;
    endfunction

    function automatic bit m_act(int i);
        return m_en[i] && m_en[parent(i)];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NSW; i++) begin
            m_en[i] = 0; m_tr[i] = 0; m_fo[i] = 0; m_cnt[i] = 0;
        end
        m_pend = 0; m_scnt = 0;
    endtask

    // Expected next state from R2..R11, using inputs of this edge.
    task automatic model_edge();
        bit ne[NSW]; bit nt[NSW]; bit nf[NSW]; int nc[NSW];
        bit ok, cancel, fire, en0;
        ok  = cmd_valid && (int'(cmd_idx) < NSW);
        en0 = m_en[0];
        cancel = ok && cmd_op == 8'h22 && (cmd_idx == 0 || cmd_idx == 1);
        fire   = m_pend && m_scnt == 0 && !cancel;
        for (int i = 0; i < NSW; i++) begin
            bit sel, gate, ron, roff, rres, rfor, act, hit;
            sel  = ok && int'(cmd_idx) == i;
            gate = (i == 1) ? en0 : 1'b1;
            ron  = gate && ((sel && cmd_op == 8'h11) ||
                            (i == 0 && cmd_valid && cmd_op == 8'h55) || (i == 1 && fire));
            roff = sel && cmd_op == 8'h22;
            rres = gate && sel && cmd_op == 8'h33;
            rfor = gate && sel && cmd_op == 8'h44;
            act  = m_act(i);
            hit  = act && oc_in[i] && m_cnt[i] == OCN - 1;
            nc[i] = hit ? 0 : ((act && oc_in[i]) ? m_cnt[i] + 1 : 0);
            ne[i] = m_en[i]; nt[i] = m_tr[i]; nf[i] = m_fo[i];
            if (roff) begin ne[i] = 0; nf[i] = 0; end
            else if (rfor) begin ne[i] = 1; nf[i] = 1; end
            else if (rres) begin ne[i] = 1; nt[i] = 0; end
            else if (ron && !m_tr[i]) ne[i] = 1;
            if (hit) begin nt[i] = 1; if (!nf[i]) ne[i] = 0; end
        end
        if (cmd_valid && cmd_op == 8'h55) begin m_pend = 1; m_scnt = int'(cfg_seq_dly); end
        else if (cancel || fire) m_pend = 0;
        else if (m_pend) m_scnt = m_scnt - 1;
        for (int i = 0; i < NSW; i++) begin
            m_en[i] = ne[i]; m_tr[i] = nt[i]; m_fo[i] = nf[i]; m_cnt[i] = nc[i];
        end
    endtask

    task automatic compare();
        logic [NSW-1:0] eo; logic [3*NSW-1:0] es;
        for (int i = 0; i < NSW; i++) begin
            eo[i] = m_act(i);
            es[3*i] = m_en[i]; es[3*i+1] = m_tr[i]; es[3*i+2] = m_fo[i];
        end
        n_chk++;
        if (sw_out !== eo || status !== es) begin
            n_bad++;
            $display("FAIL %s: sw_out=%h status=%h expected sw_out=%h status=%h",
                     cur_req, sw_out, status, eo, es);
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cmd(logic [7:0] op, logic [7:0] idx);
        cmd_valid = 1; cmd_op = op; cmd_idx = idx;
        step();
        cmd_valid = 0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        void'($urandom(32'h5EED));
        model_reset();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1 out", 32'(sw_out), 0);
        chk("R1 status", 32'(status), 0);
        rst_n = 1;
        idle(2);

        cur_req = "R7";
        cmd(8'h11, 8'd1);
        chk("R7 high rail rejected", 32'(status[3]), 0);

        cur_req = "R3";
        cmd(8'h11, 8'd3);
        chk("R3 branch without parent", 32'(sw_out[3]), 0);
        chk("R3 branch enable bit", 32'(status[9]), 1);
        cmd(8'h11, 8'd0);
        chk("R3 branch with parent", 32'(sw_out[3]), 1);

        cur_req = "R4";
        oc_in[3] = 1; idle(3); oc_in[3] = 0; idle(1);
        chk("R4 short run no trip", 32'(status[10]), 0);
        chk("R4 short run output", 32'(sw_out[3]), 1);
        oc_in[3] = 1; idle(4); oc_in[3] = 0;
        chk("R4 trip flag", 32'(status[10]), 1);
        chk("R4 trip off", 32'(sw_out[3]), 0);

        cur_req = "R2";
        cmd(8'h11, 8'd3);
        chk("R2 on ignored while tripped", 32'(status[9]), 0);
        cur_req = "R5";
        cmd(8'h33, 8'd3);
        chk("R5 reset clears trip", 32'(status[11:9]), 32'b001);

        cur_req = "R6";
        cmd(8'h44, 8'd3);
        oc_in[3] = 1; idle(6);
        chk("R6 forced stays on, trip recorded", 32'(status[11:9]), 32'b111);
        chk("R6 forced output", 32'(sw_out[3]), 1);
        cmd(8'h22, 8'd3); oc_in[3] = 0;
        chk("R6 off ends force", 32'(status[11:9]), 32'b010);
        cmd(8'h33, 8'd3);

        cur_req = "R9";
        cmd(8'h99, 8'd2);
        cmd(8'h11, 8'd12);
        chk("R9 ignored cmds", 32'(status[8:6]), 0);

        cur_req = "R8";
        cmd(8'h22, 8'd0); cmd(8'h22, 8'd1);
        cfg_seq_dly = 8'd3;
        cmd(8'h55, 8'd7);
        chk("R8 low rail first", 32'(status[0]), 1);
        idle(3);
        chk("R8 high rail still off", 32'(status[3]), 0);
        idle(1);
        chk("R8 high rail after D+1", 32'(status[3]), 1);
        cmd(8'h22, 8'd0); cmd(8'h22, 8'd1);
        cmd(8'h55, 8'd0); idle(1);
        cmd(8'h22, 8'd1); idle(5);
        chk("R8 cancelled by off", 32'(status[3]), 0);

        cur_req = "R11/R10 random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 5);
            cmd_valid = ($urandom_range(0, 2) == 0);
            case (r)
                0: cmd_op = 8'h11;
                1: cmd_op = 8'h22;
                2: cmd_op = 8'h33;
                3: cmd_op = 8'h44;
                4: cmd_op = 8'h55;
                default: cmd_op = 8'($urandom);
            endcase
            cmd_idx = 8'($urandom_range(0, 10));
            if ($urandom_range(0, 15) == 0) cfg_seq_dly = 8'($urandom_range(0, 4));
            for (int i = 0; i < NSW; i++)
                if ($urandom_range(0, 7) == 0) oc_in[i] = ~oc_in[i];
            step();
        end
        cmd_valid = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule